// File: doc/BRIEF.md
# Power Domain Control Sequencer

This block turns software register writes into enable levels for a set of power supply units, an auxiliary power domain and a main power domain. Software uses a plain write strobe with an address and a data word. There is no read path, because every control here is write-only. One register holds one disconnect bit per supply. A second register takes command bits: one starts an automatic timed power cycle of the auxiliary domain, and the other switches the main domain off.

A supply bit set to 1 takes that unit off its source, and a bit set to 0 puts it back. When every supply is disconnected, the main domain drops with no separate command. A power-cycle command takes the auxiliary domain down for a fixed number of clocks, set by a parameter, and then brings it back by itself. A second power-cycle command that arrives during the off window is dropped. A power-down command holds the main domain off until the block is reset.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and right after reset, every supply enable (psu_en_o) is 1, the auxiliary enable (aux_en_o) is 1 and the main enable (main_en_o) is 1. A later reset also clears a latched power-down.
- R2: A write to address 0 loads its data bits [NUM_PSU-1:0] as supply disconnects, and psu_en_o[k] becomes the inverse of data bit k. The outputs change in the cycle after the write edge.
- R3: main_en_o is 0 while all supply disconnect bits are 1. It returns to 1 as soon as any supply is reconnected, provided no power-down is latched.
- R4: A write to address 1 with data bit 0 set drives aux_en_o to 0 from the write edge for exactly CYCLES_1S clock cycles. After that, aux_en_o returns to 1 with no further write.
- R5: A power-cycle write that is sampled while aux_en_o is 0 is ignored. The off window still ends CYCLES_1S cycles after the write that started it.
- R6: A write to address 1 with data bit 1 set drives main_en_o to 0 in the next cycle. It stays 0 whatever the supply writes are, until reset.
- R7: A write to any address other than 0 or 1 has no effect on the outputs. So does a write to address 1 with data bits 0 and 1 clear, and so does a cycle with wr_en_i low.
- R8: A single write to address 1 with both data bits 0 and 1 set starts the auxiliary cycle and latches power-down at the same edge. Neither action changes the supply enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr_i | input | ADDR_W | Register address (0 = supply disconnects, 1 = commands) |
| wr_data_i | input | DATA_W | Write data |
| psu_en_o | output | NUM_PSU | Per-supply connect enable, 1 = connected |
| aux_en_o | output | 1 | Auxiliary domain enable |
| main_en_o | output | 1 | Main domain enable |

## Verification
The bench builds the block with CYCLES_1S set to 20, so a full auxiliary off window fits in a few dozen clocks. That short window makes it practical to check both the exact length of the window and a retrigger that lands in the middle of it. With NUM_PSU at 2, the all-disconnected case is the two-supply case, and the bench walks every combination of supply bits. The default address and data widths are kept, so writes to unused addresses, and command writes with only the reserved bits set, can both be tried for no effect.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int unsigned SUPPLY_REG    = 0;
  localparam int unsigned CMD_REG       = 1;
  localparam int unsigned CMD_CYCLE_BIT = 0;
  localparam int unsigned CMD_DOWN_BIT  = 1;

  typedef struct packed {
    logic cycle;
    logic down;
  } cmd_t;
endpackage

// File: rtl/pwr_seq_regs.sv
`timescale 1ns/1ps
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_PSU = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_PSU-1:0] psu_off_o,
  output cmd_t               cmd_o
);
  logic sel_supply;
  logic sel_cmd;
  logic unused_data;

  assign sel_supply  = wr_en_i && (wr_addr_i == ADDR_W'(SUPPLY_REG));
  assign sel_cmd     = wr_en_i && (wr_addr_i == ADDR_W'(CMD_REG));
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psu_off_o <= '0;
    end else if (sel_supply) begin
      psu_off_o <= wr_data_i[NUM_PSU-1:0];
    end
  end

  // command bits act as one-cycle strobes; zeros carry no meaning
  always_comb begin
    cmd_o.cycle = sel_cmd & wr_data_i[CMD_CYCLE_BIT];
    cmd_o.down  = sel_cmd & wr_data_i[CMD_DOWN_BIT];
  end
endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer #(
  parameter int unsigned CYCLES = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (cnt_q == LAST) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      // start accepted only when idle
      active_o <= 1'b1;
      cnt_q    <= '0;
    end
  end
endmodule

// File: rtl/pwr_seq_domains.sv
`timescale 1ns/1ps
module pwr_seq_domains #(
  parameter int unsigned NUM_PSU = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PSU-1:0] psu_off_i,
  input  logic               down_i,
  input  logic               cycle_active_i,
  output logic [NUM_PSU-1:0] psu_en_o,
  output logic               aux_en_o,
  output logic               main_en_o
);
  logic down_q;
  logic all_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      down_q <= 1'b0;
    end else if (down_i) begin
      down_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PSU; g++) begin : g_psu
    assign psu_en_o[g] = ~psu_off_i[g];
  end

  assign all_off   = &psu_off_i;
  assign main_en_o = ~all_off & ~down_q;
  assign aux_en_o  = ~cycle_active_i;
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PSU   = 2,
  parameter int unsigned CYCLES_1S = 125_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_PSU-1:0] psu_en_o,
  output logic               aux_en_o,
  output logic               main_en_o
);
  logic [NUM_PSU-1:0] psu_off;
  cmd_t               cmd;
  logic               cycle_active;

  pwr_seq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_PSU(NUM_PSU)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .psu_off_o(psu_off),
    .cmd_o    (cmd)
  );

  pwr_seq_timer #(
    .CYCLES(CYCLES_1S)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd.cycle),
    .active_o(cycle_active)
  );

  pwr_seq_domains #(
    .NUM_PSU(NUM_PSU)
  ) u_domains (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .psu_off_i     (psu_off),
    .down_i        (cmd.down),
    .cycle_active_i(cycle_active),
    .psu_en_o      (psu_en_o),
    .aux_en_o      (aux_en_o),
    .main_en_o     (main_en_o)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PSU   = 2,
  parameter int unsigned CYCLES_1S = 125_000_000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_PSU-1:0] psu_en_o,
  input logic               aux_en_o,
  input logic               main_en_o
);
  logic        cmd_wr;
  logic        pd_seen;
  int unsigned low_cnt;

  assign cmd_wr = wr_en_i && (wr_addr_i == ADDR_W'(CMD_REG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_seen <= 1'b0;
      low_cnt <= 0;
    end else begin
      if (cmd_wr && wr_data_i[CMD_DOWN_BIT]) pd_seen <= 1'b1;
      low_cnt <= aux_en_o ? 0 : low_cnt + 1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (psu_en_o == '1 && aux_en_o && main_en_o);
    end
  end

  a_r2_supply_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(psu_en_o));

  a_r3_all_off_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psu_en_o == '0) |-> !main_en_o);

  a_r4_cycle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wr_data_i[CMD_CYCLE_BIT] && aux_en_o) |=> !aux_en_o);

  a_r4_cycle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aux_en_o && low_cnt == CYCLES_1S - 1) |=> aux_en_o);

  a_r6_down_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_seen |-> !main_en_o);
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_PSU  (NUM_PSU),
  .CYCLES_1S(CYCLES_1S)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .psu_en_o (psu_en_o),
  .aux_en_o (aux_en_o),
  .main_en_o(main_en_o)
);

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
  localparam int CYC = 20;

  typedef struct {
    logic [1:0] psu;
    logic       aux;
    logic       main;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] psu_en;
  logic       aux_en;
  logic       main_en;

  exp_t q[$];
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;

  // reference state
  int         m_left;
  logic [1:0] m_off;
  bit         m_pd;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(
    .ADDR_W(4), .DATA_W(8), .NUM_PSU(2), .CYCLES_1S(CYC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .psu_en_o(psu_en), .aux_en_o(aux_en), .main_en_o(main_en)
  );

  task automatic compare(input exp_t e);
    vectors++;
    if (psu_en !== e.psu || aux_en !== e.aux || main_en !== e.main) begin
      fails++;
      $display("FAIL %s: psu=%b aux=%b main=%b expected psu=%b aux=%b main=%b",
               e.tag, psu_en, aux_en, main_en, e.psu, e.aux, e.main);
    end
  endtask

  function automatic exp_t model_out(input string tag);
    exp_t e;
    e.psu  = ~m_off;
    e.aux  = (m_left == 0);
    e.main = (m_off != 2'b11) && !m_pd;
    e.tag  = tag;
    return e;
  endfunction

  task automatic apply(input logic we, input logic [3:0] addr,
                       input logic [7:0] data, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = addr; wr_data = data;
    if (m_left > 0) m_left--;
    else if (we && addr == 4'd1 && data[0]) m_left = CYC;
    if (we && addr == 4'd0) m_off = data[1:0];
    if (we && addr == 4'd1 && data[1]) m_pd = 1;
    q.push_back(model_out(tag));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) apply(1'b0, 4'd0, 8'h00, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    m_left = 0; m_off = 2'b00; m_pd = 0;
    #1;
    compare(model_out(tag));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    m_left = 0; m_off = 2'b00; m_pd = 0;
    #1 rst_n = 1'b0;
    #1;
    compare(model_out("R1 reset"));
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R1 after reset");

    // supply disconnects
    apply(1, 4'd0, 8'h01, "R2 psu0 off");
    apply(1, 4'd0, 8'h02, "R2 psu1 off psu0 on");
    apply(1, 4'd0, 8'h03, "R3 both off");
    idle(2, "R3 both off hold");
    apply(1, 4'd0, 8'h00, "R3 both on");
    apply(1, 4'd0, 8'h03, "R3 both off again");
    apply(1, 4'd0, 8'h01, "R3 one reconnected");
    apply(1, 4'd0, 8'hFC, "R2 upper bits only");

    // writes with no effect
    apply(0, 4'd0, 8'h03, "R7 strobe low");
    apply(1, 4'd5, 8'hFF, "R7 other address");
    apply(1, 4'd15, 8'hFF, "R7 top address");
    apply(1, 4'd1, 8'hFC, "R7 command zeros");
    idle(2, "R7 hold");

    // timed auxiliary cycle
    apply(1, 4'd1, 8'h01, "R4 cycle start");
    idle(CYC + 4, "R4 cycle window");

    // retrigger inside the window
    apply(1, 4'd1, 8'h01, "R5 cycle start");
    idle(5, "R5 window");
    apply(1, 4'd1, 8'h01, "R5 retrigger ignored");
    apply(1, 4'd0, 8'h02, "R2 supply write during cycle");
    idle(CYC, "R5 window end");
    apply(1, 4'd1, 8'h01, "R4 restart after window");
    idle(CYC + 2, "R4 second window");

    // power-down latch
    apply(1, 4'd0, 8'h00, "R2 reconnect");
    apply(1, 4'd1, 8'h02, "R6 power down");
    apply(1, 4'd0, 8'h01, "R6 supply write keeps main off");
    apply(1, 4'd0, 8'h00, "R6 all connected main still off");
    idle(4, "R6 hold");
    do_reset("R1 reset clears power down");
    idle(2, "R1 main back after reset");

    // combined command
    apply(1, 4'd0, 8'h02, "R2 psu1 off");
    apply(1, 4'd1, 8'h03, "R8 cycle and down together");
    idle(CYC + 3, "R8 window");
    do_reset("R1 final reset");
    idle(2, "R1 final");

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule